// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block places one scan cell next to each component pin and joins the cells into a single serial path. Each cell has a fixed role set by a parameter mask. An input-role cell sits between a pin and the core. An output-role cell sits between the core and a pin. Every cell has two storage elements: a shift stage on the serial path and a parallel hold register behind it.

A test access controller outside this block drives the cells with three strobes: capture, shift and update. Capture loads each shift stage with the functional value the cell watches. Shift moves the chain one place from the serial input toward the serial output. Update copies the shift stages into the hold registers on the falling test-clock edge, so the driven values stay still while data is shifted. When the test-mode select is high, the hold registers take over the driven side of every cell. When it is low, both functional paths pass straight through.

Top module: `bsc_chain`

## Requirements
- R1: While `trst_n` is low, every shift stage and hold register is 0, so `scan_out` is 0 and, with `test_mode` high, `core_in` of input cells and `pin_out` of output cells are 0. Assertion of `trst_n` takes effect at once. Release takes effect on the second following rising `tck` edge.
- R2: When `capture_en` is high at a rising `tck` edge, the shift stage of cell i loads `pin_in[i]` for an input cell and `core_out[i]` for an output cell. Capture wins when `shift_en` is also high.
- R3: When `shift_en` is high and `capture_en` low at a rising `tck` edge, cell 0 loads `scan_in` and cell i loads the old value of cell i-1. `scan_out` always shows the shift stage of the last cell, N-1.
- R4: When neither `capture_en` nor `shift_en` is high at a rising `tck` edge, every shift stage keeps its value.
- R5: When `update_en` is high at a falling `tck` edge, every hold register loads its cell's shift stage. Otherwise the hold registers keep their values, so the driven outputs do not move while the chain shifts.
- R6: With `test_mode` high, an input cell drives `core_in[i]` from its hold register and passes `core_out[i]` to `pin_out[i]`. An output cell drives `pin_out[i]` from its hold register and passes `pin_in[i]` to `core_in[i]`.
- R7: With `test_mode` low, `core_in` equals `pin_in` and `pin_out` equals `core_out`.
- R8: Bit i of parameter `PIN_IS_INPUT` set to 1 makes cell i an input cell; 0 makes it an output cell. The default for 8 pins is 8'h0F: cells 0 to 3 are inputs and cells 4 to 7 are outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset, asynchronous assert |
| capture_en | input | 1 | Parallel capture strobe |
| shift_en | input | 1 | Serial shift strobe |
| update_en | input | 1 | Hold-register update strobe, taken on falling edge |
| test_mode | input | 1 | Hold registers drive the cell outputs when high |
| scan_in | input | 1 | Serial data into cell 0 |
| scan_out | output | 1 | Serial data from cell N-1 |
| pin_in | input | NUM_PINS | Values arriving from the pins |
| core_out | input | NUM_PINS | Values the core wants on the pins |
| core_in | output | NUM_PINS | Values delivered to the core |
| pin_out | output | NUM_PINS | Values delivered to the pins |

## Verification
Directed capture with pin and core words that differ in every role half shows whether each cell samples the side its role names. Capture and shift are then raised together to show which one wins. Long serial runs with random data, read bit by bit at the serial output, separate a correct one-place shift from skipped or reordered stages. Checking the driven outputs after every shift step, with update held low, shows that the hold registers stay still. Random mixes of all strobes, the mode select and the functional words, plus a reset in the middle of the run, compare every output after each edge against a bench model of stages and hold registers.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic {
    ROLE_OUT = 1'b0,
    ROLE_IN  = 1'b1
  } cell_role_e;

  function automatic cell_role_e role_of(input logic is_input);
    return is_input ? ROLE_IN : ROLE_OUT;
  endfunction

endpackage

// File: rtl/bsc_rst_sync.sv
module bsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic tck,
  input  logic trst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/bsc_cell.sv
module bsc_cell
  import bsc_pkg::*;
#(
  parameter cell_role_e ROLE = ROLE_IN
) (
  input  logic tck,
  input  logic rst_n,
  input  logic capture_en,
  input  logic shift_en,
  input  logic update_en,
  input  logic test_mode,
  input  logic serial_in,
  input  logic pin_in,
  input  logic core_out,
  output logic core_in,
  output logic pin_out,
  output logic serial_out
);

  logic func_val;
  logic stage_q;
  logic stage_d;
  logic stage_en;
  logic hold_q;
  logic hold_d;

  // Role chooses observed side and driven side
  generate
    if (ROLE == ROLE_IN) begin : g_in
      assign func_val = pin_in;
      assign core_in  = test_mode ? hold_q : pin_in;
      assign pin_out  = core_out;
    end else begin : g_out
      assign func_val = core_out;
      assign pin_out  = test_mode ? hold_q : core_out;
      assign core_in  = pin_in;
    end
  endgenerate

  // Shift stage next state: capture has priority over shift
  always_comb begin
    stage_en = capture_en | shift_en;
    stage_d  = stage_q;
    if (capture_en) begin
      stage_d = func_val;
    end else if (shift_en) begin
      stage_d = serial_in;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
    end else if (stage_en) begin
      stage_q <= stage_d;
    end
  end

  // Hold register loads on the falling edge
  always_comb begin
    hold_d = stage_q;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else if (update_en) begin
      hold_q <= hold_d;
    end
  end

  assign serial_out = stage_q;

  AST_CAPTURE_LOAD: assert property (@(posedge tck) disable iff (!rst_n)
    capture_en |=> (stage_q == $past(func_val))); // R2

  AST_SHIFT_MOVE: assert property (@(posedge tck) disable iff (!rst_n)
    (shift_en && !capture_en) |=> (serial_out == $past(serial_in))); // R3

  AST_IDLE_KEEP: assert property (@(posedge tck) disable iff (!rst_n)
    (!shift_en && !capture_en) |=> $stable(serial_out)); // R4

  AST_HOLD_STILL: assert property (@(negedge tck) disable iff (!rst_n)
    !update_en |=> $stable(hold_q)); // R5

endmodule

// File: rtl/bsc_chain.sv
module bsc_chain
  import bsc_pkg::*;
#(
  parameter int                    NUM_PINS     = 8,
  parameter logic [NUM_PINS-1:0]   PIN_IS_INPUT = 8'h0F,
  parameter int                    SYNC_STAGES  = 2
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                capture_en,
  input  logic                shift_en,
  input  logic                update_en,
  input  logic                test_mode,
  input  logic                scan_in,
  output logic                scan_out,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] core_out,
  output logic [NUM_PINS-1:0] core_in,
  output logic [NUM_PINS-1:0] pin_out
);

  localparam int LINKS = NUM_PINS + 1;

  logic             rst_n;
  logic [LINKS-1:0] link;

  bsc_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .tck    (tck),
    .trst_n (trst_n),
    .rst_n  (rst_n)
  );

  assign link[0] = scan_in;

  // One cell per pin, role picked by mask bit (R8)
  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_cell
      bsc_cell #(
        .ROLE (role_of(PIN_IS_INPUT[i]))
      ) u_cell (
        .tck        (tck),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .update_en  (update_en),
        .test_mode  (test_mode),
        .serial_in  (link[i]),
        .pin_in     (pin_in[i]),
        .core_out   (core_out[i]),
        .core_in    (core_in[i]),
        .pin_out    (pin_out[i]),
        .serial_out (link[i+1])
      );
    end
  endgenerate

  assign scan_out = link[LINKS-1];

  AST_PASS_THROUGH: assert property (@(posedge tck) disable iff (!rst_n)
    !test_mode |-> (core_in == pin_in && pin_out == core_out)); // R7

  AST_SHIFT_OUT: assert property (@(posedge tck) disable iff (!rst_n)
    (shift_en && !capture_en) |=> (scan_out == $past(link[LINKS-2]))); // R3

endmodule

// File: tb/bsc_chain_bench.sv
module bsc_chain_bench;

  localparam int          N    = 8;
  localparam logic [N-1:0] MASK = 8'h0F;

  logic         tck, trst_n, capture_en, shift_en, update_en, test_mode, scan_in;
  logic         scan_out;
  logic [N-1:0] pin_in, core_out, core_in, pin_out;

  logic [N-1:0] m_st, m_hold;
  int           n_run, n_fail;
  bit           done;

  bsc_chain #(.NUM_PINS(N), .PIN_IS_INPUT(MASK)) u_bsc_chain (
    .tck(tck), .trst_n(trst_n), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .test_mode(test_mode), .scan_in(scan_in),
    .scan_out(scan_out), .pin_in(pin_in), .core_out(core_out),
    .core_in(core_in), .pin_out(pin_out)
  );

  initial tck = 1'b0;
  always #5 tck = ~tck;

  function automatic logic [N-1:0] exp_core_in(logic [N-1:0] hold, logic [N-1:0] pin, logic tm);
    return (tm ? ((MASK & hold) | (~MASK & pin)) : pin);
  endfunction

  function automatic logic [N-1:0] exp_pin_out(logic [N-1:0] hold, logic [N-1:0] core, logic tm);
    return (tm ? ((~MASK & hold) | (MASK & core)) : core);
  endfunction

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, core_in, exp_core_in(m_hold, pin_in, test_mode));
    chk(req, pin_out, exp_pin_out(m_hold, core_out, test_mode));
    chk(req, {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, m_st[N-1]});
  endtask

  // Drive just after a falling edge; model the rising and falling edge
  task automatic step(logic cap, logic sh, logic upd, logic sin);
    capture_en = cap; shift_en = sh; update_en = upd; scan_in = sin;
    @(posedge tck);
    if (trst_n) begin
      if (cap)     m_st = (MASK & pin_in) | (~MASK & core_out);
      else if (sh) m_st = {m_st[N-2:0], sin};
    end
    @(negedge tck);
    if (upd && trst_n) m_hold = m_st;
    #1;
  endtask

  initial begin
    done = 0;
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0;
    void'($urandom(32'h5eed_1234));
    trst_n = 0; capture_en = 0; shift_en = 0; update_en = 0; scan_in = 0;
    test_mode = 1; pin_in = 8'hFF; core_out = 8'hFF;
    m_st = '0; m_hold = '0;
    @(negedge tck); #1;
    check_all("R1 reset");
    step(1, 0, 1, 1);
    check_all("R1 reset ignores strobes");
    trst_n = 1;
    step(0, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
    check_all("R1 after release");

    // R2 / R8 directed capture with differing halves
    pin_in = 8'hA5; core_out = 8'h3C;
    step(1, 0, 1, 0);
    check_all("R2 capture roles R8");
    chk("R2 capture value", m_hold, 8'h35);

    // R2 capture priority over shift
    pin_in = 8'h5A; core_out = 8'hC3;
    step(1, 1, 0, 1);
    check_all("R2 priority");

    // R3 shift out with random data, R5 outputs still
    for (int i = 0; i < 2 * N; i++) begin
      step(0, 1, 0, 1'($urandom));
      check_all("R3 shift R5 hold still");
    end
    step(0, 0, 1, 0);
    check_all("R5 update after shift");

    // R4 idle keeps stages
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 0, 1);
      check_all("R4 idle");
    end
    step(0, 0, 1, 0);
    check_all("R4 idle then update");

    // R6 / R7 mode select
    test_mode = 0;
    for (int i = 0; i < 6; i++) begin
      pin_in = 8'($urandom); core_out = 8'($urandom);
      step(0, 0, 0, 0);
      check_all("R7 pass through");
    end
    test_mode = 1;
    step(0, 0, 0, 0);
    check_all("R6 test drive");

    // Random mix
    for (int i = 0; i < 300; i++) begin
      pin_in = 8'($urandom); core_out = 8'($urandom);
      test_mode = 1'($urandom);
      step(1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom_range(0, 2) == 0),
           1'($urandom));
      check_all("R2/R3/R5/R6 random");
    end

    // Mid-run reset: immediate clear
    test_mode = 1;
    step(1, 0, 1, 0);
    trst_n = 0; m_st = '0; m_hold = '0;
    #1;
    check_all("R1 mid-run reset");
    step(0, 0, 0, 0);
    trst_n = 1;
    step(0, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
    check_all("R1 mid-run release");
    pin_in = 8'h0F; core_out = 8'hF0;
    step(1, 0, 1, 0);
    check_all("R2 after reset R8");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule